// File: doc/BRIEF.md
# Wrapping DMA Address Generator

This block produces the word-aligned addresses for both sides of one DMA channel. It has a memory side and a peripheral side. Each side keeps a base pointer and a current address. Each accepted beat moves that side's current address on by one 32-bit word. When a side is given a nonzero wrap code, its address returns to the base once a window of words has been covered. The transfer can then cycle over a ring buffer, or keep hitting a fixed FIFO register, without software stepping in.

The two sides decode their 3-bit wrap code through separate power-of-two tables. Each table's smallest window is set by a parameter. With the defaults, the memory side gives windows of 32 to 2048 words and the peripheral side gives windows of 1 to 64 words. Code 0 means no wrap on either side. The wrap code is captured together with the pointer on a load. A load restarts the window.

Top module: `dma_wrap_addr_gen`

## Requirements
- R1: After reset both addresses read 0. The memory side comes up with wrap code 0, so each beat adds 4 to its address. The peripheral side comes up with wrap code 1, so its address stays at 0 while it steps.
- R2: One cycle after a load, the side's address equals the loaded pointer with bits [1:0] cleared.
- R3: With wrap code 0, each beat adds 4 to the address, with no bound.
- R4: On the memory side, a code k from 1 to 7 selects a window of 32·2^(k-1) words. After N-1 beats from a load the address is base+4(N-1). Beat N returns it to base, and the sequence then repeats.
- R5: On the peripheral side, a code k from 1 to 7 selects a window of 2^(k-1) words, and the address follows the same pattern as in R4. Code 1 keeps the address fixed at base.
- R6: The wrap code is sampled only on a load. A change on the wrap input without a load has no effect on the address sequence.
- R7: A load in the same cycle as a beat takes priority. The load also restarts the beat count within the window.
- R8: With neither a load nor a beat, the address holds its value.
- R9: The two sides are independent. A load, beat or code on one side has no effect on the other side.
- R10: Bits [1:0] of both address outputs are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_load_i | input | 1 | Load the memory-side pointer and wrap code |
| mem_ptr_i | input | AW | Memory-side byte pointer; bits [1:0] are ignored |
| mem_wrap_i | input | 3 | Memory-side wrap code |
| mem_step_i | input | 1 | Memory-side accepted beat |
| mem_addr_o | output | AW | Memory-side current byte address |
| per_load_i | input | 1 | Load the peripheral-side pointer and wrap code |
| per_ptr_i | input | AW | Peripheral-side byte pointer; bits [1:0] are ignored |
| per_wrap_i | input | 3 | Peripheral-side wrap code |
| per_step_i | input | 1 | Peripheral-side accepted beat |
| per_addr_o | output | AW | Peripheral-side current byte address |

## Verification
A wrong beat counter or a wrong latched code shows only at a window boundary. The address then returns to base one beat early or late, or it runs past base+4(N-1). Such a fault therefore appears within one window of beats after a load, and the bench walks every code on both sides through at least one full wrap. A wrong base register shows at the first wrap, and a wrong load path shows in the very next cycle.

// File: rtl/dma_wrap_pkg.sv
package dma_wrap_pkg;
  localparam int unsigned WRAP_CODE_W = 3;
  localparam int unsigned NUM_CODES   = 1 << WRAP_CODE_W;
  localparam int unsigned BYTE_BITS   = 2;

  typedef logic [WRAP_CODE_W-1:0] wrap_code_t;

  // counter width for a table whose code-1 window is 2**base_log2 words
  function automatic int unsigned cnt_width(int unsigned base_log2);
    return base_log2 + NUM_CODES - 2;
  endfunction
endpackage

// File: rtl/dma_wrap_decode.sv
module dma_wrap_decode
  import dma_wrap_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 0,
  localparam int unsigned CNT_W = (cnt_width(BASE_LOG2) > 0) ? cnt_width(BASE_LOG2) : 1
) (
  input  wrap_code_t       code_i,
  output logic             wrap_en_o,
  output logic [CNT_W-1:0] last_beat_o
);
  logic [CNT_W-1:0] last_tbl [NUM_CODES];

  for (genvar k = 0; k < NUM_CODES; k++) begin : g_tbl
    if (k == 0) begin : g_nowrap
      assign last_tbl[k] = '0;
    end else begin : g_win
      assign last_tbl[k] = CNT_W'((64'd1 << (BASE_LOG2 + k - 1)) - 64'd1);
    end
  end

  assign wrap_en_o   = (code_i != '0);
  assign last_beat_o = last_tbl[code_i];
endmodule

// File: rtl/dma_wrap_side.sv
module dma_wrap_side
  import dma_wrap_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned BASE_LOG2 = 0,
  parameter int unsigned RST_CODE  = 0,
  localparam int unsigned WORD_W = AW - BYTE_BITS,
  localparam int unsigned CNT_W  = (cnt_width(BASE_LOG2) > 0) ? cnt_width(BASE_LOG2) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] ptr_i,
  input  wrap_code_t    wrap_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  logic [WORD_W-1:0] base_q, word_q;
  logic [CNT_W-1:0]  cnt_q, last_beat;
  wrap_code_t        code_q;
  logic              wrap_en, at_end;
  logic              unused_lsb;

  assign unused_lsb = ^ptr_i[BYTE_BITS-1:0];

  dma_wrap_decode #(.BASE_LOG2(BASE_LOG2)) i_decode (
    .code_i      (code_q),
    .wrap_en_o   (wrap_en),
    .last_beat_o (last_beat)
  );

  assign at_end = wrap_en && (cnt_q == last_beat);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      word_q <= '0;
      cnt_q  <= '0;
      code_q <= wrap_code_t'(RST_CODE);
    end else if (load_i) begin
      base_q <= ptr_i[AW-1:BYTE_BITS];
      word_q <= ptr_i[AW-1:BYTE_BITS];
      cnt_q  <= '0;
      code_q <= wrap_i;
    end else if (step_i) begin
      if (at_end) begin
        word_q <= base_q;
        cnt_q  <= '0;
      end else begin
        word_q <= word_q + 1'b1;
        if (wrap_en) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign addr_o = {word_q, {BYTE_BITS{1'b0}}};
endmodule

// File: rtl/dma_wrap_addr_gen.sv
module dma_wrap_addr_gen
  import dma_wrap_pkg::*;
#(
  parameter int unsigned AW            = 32,
  parameter int unsigned MEM_BASE_LOG2 = 5,
  parameter int unsigned PER_BASE_LOG2 = 0,
  parameter int unsigned MEM_RST_CODE  = 0,
  parameter int unsigned PER_RST_CODE  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mem_load_i,
  input  logic [AW-1:0] mem_ptr_i,
  input  logic [2:0]    mem_wrap_i,
  input  logic          mem_step_i,
  output logic [AW-1:0] mem_addr_o,
  input  logic          per_load_i,
  input  logic [AW-1:0] per_ptr_i,
  input  logic [2:0]    per_wrap_i,
  input  logic          per_step_i,
  output logic [AW-1:0] per_addr_o
);
  dma_wrap_side #(
    .AW(AW), .BASE_LOG2(MEM_BASE_LOG2), .RST_CODE(MEM_RST_CODE)
  ) i_mem_side (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (mem_load_i),
    .ptr_i  (mem_ptr_i),
    .wrap_i (mem_wrap_i),
    .step_i (mem_step_i),
    .addr_o (mem_addr_o)
  );

  dma_wrap_side #(
    .AW(AW), .BASE_LOG2(PER_BASE_LOG2), .RST_CODE(PER_RST_CODE)
  ) i_per_side (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (per_load_i),
    .ptr_i  (per_ptr_i),
    .wrap_i (per_wrap_i),
    .step_i (per_step_i),
    .addr_o (per_addr_o)
  );
endmodule

// File: rtl/dma_wrap_addr_gen_chk.sv
module dma_wrap_addr_gen_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_load_i,
  input logic [AW-1:0] mem_ptr_i,
  input logic          mem_step_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          per_load_i,
  input logic [AW-1:0] per_ptr_i,
  input logic          per_step_i,
  input logic [AW-1:0] per_addr_o
);
  localparam logic [AW-1:0] LSB_CLR = ~AW'(3);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !past_ok |-> (mem_addr_o == '0 && per_addr_o == '0));

  // R2
  mem_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && mem_load_i) |=> mem_addr_o == ($past(mem_ptr_i) & LSB_CLR));

  // R2
  per_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && per_load_i) |=> per_addr_o == ($past(per_ptr_i) & LSB_CLR));

  // R8
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !mem_load_i && !mem_step_i) |=> $stable(mem_addr_o));

  // R8
  per_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !per_load_i && !per_step_i) |=> $stable(per_addr_o));

  // R4
  mem_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && mem_step_i && !mem_load_i) |=>
      (mem_addr_o == $past(mem_addr_o) + AW'(4) || mem_addr_o <= $past(mem_addr_o)));

  // R5
  per_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && per_step_i && !per_load_i) |=>
      (per_addr_o == $past(per_addr_o) + AW'(4) || per_addr_o <= $past(per_addr_o)));

  // R10
  lsb_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (mem_addr_o[1:0] == 2'b00 && per_addr_o[1:0] == 2'b00));
endmodule

bind dma_wrap_addr_gen dma_wrap_addr_gen_chk #(.AW(AW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_load_i (mem_load_i),
  .mem_ptr_i  (mem_ptr_i),
  .mem_step_i (mem_step_i),
  .mem_addr_o (mem_addr_o),
  .per_load_i (per_load_i),
  .per_ptr_i  (per_ptr_i),
  .per_step_i (per_step_i),
  .per_addr_o (per_addr_o)
);

// File: tb/test_dma_wrap_addr_gen.sv
module test_dma_wrap_addr_gen;
  localparam int unsigned AW = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mem_load_i = 1'b0, mem_step_i = 1'b0;
  logic [AW-1:0] mem_ptr_i = '0;
  logic [2:0]    mem_wrap_i = '0;
  logic          per_load_i = 1'b0, per_step_i = 1'b0;
  logic [AW-1:0] per_ptr_i = '0;
  logic [2:0]    per_wrap_i = '0;
  logic [AW-1:0] mem_addr_o, per_addr_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dma_wrap_addr_gen i_dma_wrap_addr_gen (
    .clk_i(clk), .rst_ni(rst_ni),
    .mem_load_i(mem_load_i), .mem_ptr_i(mem_ptr_i), .mem_wrap_i(mem_wrap_i),
    .mem_step_i(mem_step_i), .mem_addr_o(mem_addr_o),
    .per_load_i(per_load_i), .per_ptr_i(per_ptr_i), .per_wrap_i(per_wrap_i),
    .per_step_i(per_step_i), .per_addr_o(per_addr_o)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // side 0 = memory, 1 = peripheral
  task automatic load(input bit side, input logic [AW-1:0] ptr, input logic [2:0] code);
    if (side) begin per_load_i = 1'b1; per_ptr_i = ptr; per_wrap_i = code; end
    else      begin mem_load_i = 1'b1; mem_ptr_i = ptr; mem_wrap_i = code; end
    @(posedge clk); #1;
    mem_load_i = 1'b0; per_load_i = 1'b0;
  endtask

  task automatic step(input bit side, input int n);
    if (side) per_step_i = 1'b1; else mem_step_i = 1'b1;
    repeat (n) @(posedge clk);
    #1;
    mem_step_i = 1'b0; per_step_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mem reset", mem_addr_o, '0);
    chk("R1 per reset", per_addr_o, '0);
    step(1, 3);
    chk("R1 per default code 1", per_addr_o, '0);
    step(0, 2);
    chk("R1 mem default code 0", mem_addr_o, 32'h8);
  endtask

  task automatic t_load();
    load(0, 32'h1000_0003, 3'd0);
    chk("R2 mem load", mem_addr_o, 32'h1000_0000);
    chk("R10 mem lsb", {30'd0, mem_addr_o[1:0]}, '0);
    load(1, 32'h7000_0042, 3'd1);
    chk("R2 per load", per_addr_o, 32'h7000_0040);
  endtask

  task automatic t_nowrap();
    load(0, 32'h100, 3'd0);
    step(0, 40);
    chk("R3 no wrap", mem_addr_o, 32'h100 + 160);
    load(1, 32'h200, 3'd0);
    step(1, 70);
    chk("R3 per no wrap", per_addr_o, 32'h200 + 280);
  endtask

  task automatic t_wrap(input bit side, input string req);
    for (int k = 1; k < 8; k++) begin
      int win = side ? (1 << (k - 1)) : (32 << (k - 1));
      logic [AW-1:0] base = side ? 32'h0000_4000 : 32'h0002_0000;
      load(side, base, 3'(k));
      step(side, win - 1);
      chk($sformatf("%s code %0d last", req, k), side ? per_addr_o : mem_addr_o,
          base + AW'(4 * (win - 1)));
      step(side, 1);
      chk($sformatf("%s code %0d wrap", req, k), side ? per_addr_o : mem_addr_o, base);
      step(side, 1);
      chk($sformatf("%s code %0d after", req, k), side ? per_addr_o : mem_addr_o,
          (win == 1) ? base : base + 4);
    end
  endtask

  task automatic t_latch();
    load(1, 32'h40, 3'd3);
    per_wrap_i = 3'd0;
    step(1, 4);
    chk("R6 code latched", per_addr_o, 32'h40);
    mem_wrap_i = 3'd1;
    load(0, 32'h800, 3'd0);
    mem_wrap_i = 3'd1;
    step(0, 33);
    chk("R6 mem code latched", mem_addr_o, 32'h800 + 132);
  endtask

  task automatic t_reload();
    load(0, 32'h500, 3'd1);
    step(0, 10);
    mem_step_i = 1'b1;
    load(0, 32'h600, 3'd1);
    chk("R7 load over step", mem_addr_o, 32'h600);
    step(0, 31);
    chk("R7 window restarted", mem_addr_o, 32'h600 + 124);
    step(0, 1);
    chk("R7 wrap after reload", mem_addr_o, 32'h600);
  endtask

  task automatic t_hold();
    logic [AW-1:0] m, p;
    load(0, 32'h900, 3'd2);
    step(0, 3);
    m = mem_addr_o; p = per_addr_o;
    repeat (5) @(posedge clk);
    #1;
    chk("R8 mem hold", mem_addr_o, m);
    chk("R8 per hold", per_addr_o, p);
  endtask

  task automatic t_indep();
    load(0, 32'hA00, 3'd2);
    load(1, 32'hB00, 3'd2);
    mem_step_i = 1'b1; per_step_i = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    mem_step_i = 1'b0; per_step_i = 1'b0;
    chk("R9 mem side", mem_addr_o, 32'hA00 + 20);
    chk("R9 per side", per_addr_o, 32'hB00 + 4);
    load(1, 32'hC00, 3'd5);
    chk("R9 mem untouched", mem_addr_o, 32'hA00 + 20);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    t_reset();
    t_load();
    t_nowrap();
    t_wrap(0, "R4 mem");
    t_wrap(1, "R5 per");
    t_latch();
    t_reload();
    t_hold();
    t_indep();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule